// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Handling

This block recovers characters from an asynchronous serial line. It runs from a strobe `tick_i` that pulses 16 times per bit period; the baud-rate divider that makes this strobe sits outside the block. The receiver passes the line through a synchroniser. It confirms a start bit at the bit centre, then samples each data bit, the optional parity bit and the stop bit at their centres. It puts out each character together with its error flags on a single-cycle strobe.

Word length, parity and stop-bit count are configuration inputs. They are sampled live, so the surrounding logic changes them only while the line is idle. When a whole character time reads as zero, the character is reported as a break. The receiver then stays silent until the line goes back to the marking level and a new start bit is confirmed. Any character whose first stop bit reads low ends in the same wait for a high line, so a line held low never produces a stream of characters.

Top module: `uart_brk_rx`

## Requirements
- R1: While `rst_ni` is low and after its release, `valid_o`, `data_o`, `frame_err_o`, `parity_err_o` and `break_o` are all zero.
- R2: `wlen_i` selects the number of data bits: 0→5, 1→6, 2→7, 3→8. Bits are received LSB first and placed from `data_o[0]` upward. Bits above the word length read zero.
- R3: With `par_en_i` set, one parity bit follows the data. `par_odd_i`=0 means even parity and 1 means odd parity, counted over the data bits plus the parity bit. A mismatch sets `parity_err_o` for that character. With `par_en_i` clear, no parity bit is expected and `parity_err_o` stays 0.
- R4: A character whose first stop bit samples low, and which is not a break, is delivered with `frame_err_o`=1. A character whose stop bit samples high is delivered with `frame_err_o`=0.
- R5: With `two_stop_i` set, only the first stop bit is checked. A low second stop bit raises no framing error and does not start a new character.
- R6: If every data bit, the parity bit (when enabled) and the first stop bit all sample low, exactly one character is delivered with `data_o`=0 and `break_o`=1. In that case `frame_err_o` and `parity_err_o` are 0.
- R7: After a break, no character is delivered while the line stays low. Reception resumes only after the line returns high and a new start bit is confirmed.
- R8: A low pulse shorter than half a bit period (fewer than 8 ticks) is a false start and delivers no character.
- R9: `valid_o` is high for exactly one clock per character. The data and flags are valid in that cycle.
- R10: Reception works with `tick_i` held high every clock, so the line can run at one sixteenth of the clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling strobe, 16 per bit period |
| rxd_i | input | 1 | Serial line, idle high |
| wlen_i | input | 2 | Data bits: 0→5, 1→6, 2→7, 3→8 |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 0 even parity, 1 odd parity |
| two_stop_i | input | 1 | Two stop bits when set |
| data_o | output | 8 | Received character, LSB aligned |
| valid_o | output | 1 | One-cycle strobe marking a delivered character |
| frame_err_o | output | 1 | First stop bit sampled low |
| parity_err_o | output | 1 | Parity mismatch |
| break_o | output | 1 | Character is a break |

## Verification
The hardest condition to reach from the ports is the lock after a break. The line must be held low well past one character time, and the bench must then show that no second zero character appears. The stimulus holds the line low for three full character times and counts the strobes during that interval. It then releases the line and sends a normal character to prove that reception resumes. Random frames draw word length, parity, stop count, tick rate, bad stop bits and flipped parity from a fixed seed. Some of them therefore land on all-zero frames, which must be classed as breaks rather than framing errors.

// File: rtl/uart_brk_rx_pkg.sv
package uart_brk_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2, ST_WAITHI
  } rx_state_e;

  // wlen code 0..3 -> 5..8 data bits
  function automatic logic [3:0] word_bits(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction
endpackage

// File: rtl/uart_brk_rx_sync.sv
module uart_brk_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_brk_rx_timer.sv
module uart_brk_rx_timer #(
  parameter int OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic restart_i,
  output logic mid_o,
  output logic end_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID_V = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] END_V = CNT_W'(OVS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= (cnt_q == END_V) ? '0 : cnt_q + 1'b1;
  end

  assign mid_o = tick_i && (cnt_q == MID_V);
  assign end_o = tick_i && (cnt_q == END_V);
endmodule

// File: rtl/uart_brk_rx_fsm.sv
module uart_brk_rx_fsm
  import uart_brk_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              mid_i,
  input  logic              end_i,
  input  logic [1:0]        wlen_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  output logic              restart_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fe_o,
  output logic              pe_o,
  output logic              brk_o
);
  localparam int BW = $clog2(DATA_W);

  rx_state_e         state_q;
  logic [DATA_W-1:0] sh_q;
  logic [BW-1:0]     bit_q;
  logic              par_q;
  logic              ones_q;
  logic [3:0]        nbits;
  logic              last_bit;
  logic [DATA_W-1:0] aligned;
  logic              is_brk;

  assign nbits    = word_bits(wlen_i);
  assign last_bit = (int'(bit_q) == int'(nbits) - 1);
  assign aligned  = sh_q >> (DATA_W - int'(nbits));
  // all sampled bits zero, including the stop bit now on the line
  assign is_brk   = !rx_i && !ones_q;

  assign restart_o = (state_q == ST_IDLE) || (state_q == ST_WAITHI) ||
                     ((state_q == ST_START) && mid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      par_q   <= 1'b0;
      ones_q  <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
      fe_o    <= 1'b0;
      pe_o    <= 1'b0;
      brk_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (!rx_i) state_q <= ST_START;
        ST_START: if (mid_i) begin
          if (!rx_i) begin
            state_q <= ST_DATA;
            sh_q    <= '0;
            bit_q   <= '0;
            par_q   <= 1'b0;
            ones_q  <= 1'b0;
          end else begin
            state_q <= ST_IDLE;  // false start
          end
        end
        ST_DATA: if (end_i) begin
          sh_q   <= {rx_i, sh_q[DATA_W-1:1]};
          par_q  <= par_q ^ rx_i;
          ones_q <= ones_q | rx_i;
          if (last_bit) state_q <= par_en_i ? ST_PAR : ST_STOP1;
          else          bit_q   <= bit_q + 1'b1;
        end
        ST_PAR: if (end_i) begin
          par_q   <= par_q ^ rx_i;
          ones_q  <= ones_q | rx_i;
          state_q <= ST_STOP1;
        end
        ST_STOP1: if (end_i) begin
          valid_o <= 1'b1;
          data_o  <= aligned;
          brk_o   <= is_brk;
          fe_o    <= !rx_i && !is_brk;
          pe_o    <= par_en_i && !is_brk && (par_q ^ par_odd_i);
          state_q <= (two_stop_i && rx_i) ? ST_STOP2 : ST_WAITHI;
        end
        ST_STOP2:  if (end_i) state_q <= ST_WAITHI;
        ST_WAITHI: if (rx_i)  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx #(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       two_stop_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       frame_err_o,
  output logic       parity_err_o,
  output logic       break_o
);
  localparam int DATA_W = 8;

  logic rx_s, restart, mid, bit_end;

  uart_brk_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rx_s)
  );

  uart_brk_rx_timer #(.OVS(OVS)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .restart_i(restart),
    .mid_o(mid), .end_o(bit_end)
  );

  uart_brk_rx_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_s), .mid_i(mid), .end_i(bit_end),
    .wlen_i(wlen_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .two_stop_i(two_stop_i), .restart_o(restart), .valid_o(valid_o),
    .data_o(data_o), .fe_o(frame_err_o), .pe_o(parity_err_o), .brk_o(break_o)
  );
endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk
  import uart_brk_rx_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rxd_i,
  input logic [1:0] wlen_i,
  input logic       par_en_i,
  input logic       valid_o,
  input logic [7:0] data_o,
  input logic       frame_err_o,
  input logic       parity_err_o,
  input logic       break_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                locked_q <= 1'b0;
    else if (valid_o && break_o) locked_q <= 1'b1;
    else if (rxd_i)             locked_q <= 1'b0;
  end

  assert_strobe_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_break_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && break_o) |-> (data_o == 8'd0 && !frame_err_o && !parity_err_o));

  assert_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o >> word_bits(wlen_i)) == 8'd0));

  assert_parity_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !par_en_i) |-> !parity_err_o);

  assert_break_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |-> !valid_o);
endmodule

bind uart_brk_rx uart_brk_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rxd_i(rxd_i), .wlen_i(wlen_i),
  .par_en_i(par_en_i), .valid_o(valid_o), .data_o(data_o),
  .frame_err_o(frame_err_o), .parity_err_o(parity_err_o), .break_o(break_o)
);

// File: tb/uart_brk_rx_tb.sv
`timescale 1ns/1ps
module uart_brk_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic       pen = 1'b0, podd = 1'b0, two = 1'b0;
  logic [7:0] data_o;
  logic       valid_o, fe_o, pe_o, brk_o;

  int checks = 0, errors = 0;
  int tdiv = 4, divcnt = 0;
  int nrx = 0, adjacent = 0;
  logic prev_valid = 1'b0;
  logic [7:0] log_d [256];
  logic       log_fe[256], log_pe[256], log_brk[256];
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_brk_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd), .wlen_i(wlen),
    .par_en_i(pen), .par_odd_i(podd), .two_stop_i(two), .data_o(data_o),
    .valid_o(valid_o), .frame_err_o(fe_o), .parity_err_o(pe_o), .break_o(brk_o)
  );

  always @(negedge clk) begin
    if (divcnt >= tdiv - 1) divcnt = 0;
    else divcnt = divcnt + 1;
    tick = (divcnt == 0);
  end

  // monitor, R9: strobe never high on two consecutive cycles
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      log_d[nrx % 256]   = data_o;
      log_fe[nrx % 256]  = fe_o;
      log_pe[nrx % 256]  = pe_o;
      log_brk[nrx % 256] = brk_o;
      nrx++;
      if (prev_valid) adjacent++;
    end
    prev_valid = valid_o;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * 16 * tdiv) @(negedge clk);
  endtask

  function automatic logic [7:0] mask_w(input logic [7:0] d, input int nb);
    return d & 8'((1 << nb) - 1);
  endfunction

  task automatic run_frame(input logic [7:0] d, input logic [1:0] wl, input bit pe_en,
                           input bit odd, input bit two_s, input bit stop1,
                           input bit stop2, input bit flip);
    int nb = 5 + int'(wl);
    logic [7:0] dm = mask_w(d, nb);
    logic pb = (odd ? ~^dm : ^dm) ^ flip;
    int start;
    bit brk_e, fe_e, pe_e;
    wlen = wl; pen = pe_en; podd = odd; two = two_s;
    wait_bits(1);
    start = nrx;
    rxd = 1'b0; wait_bits(1);
    for (int i = 0; i < nb; i++) begin rxd = dm[i]; wait_bits(1); end
    if (pe_en) begin rxd = pb; wait_bits(1); end
    rxd = stop1; wait_bits(1);
    if (two_s) begin rxd = stop2; wait_bits(1); end
    rxd = 1'b1;
    wait_bits(2);
    brk_e = !stop1 && dm == 8'd0 && (!pe_en || !pb);
    fe_e  = !stop1 && !brk_e;
    pe_e  = pe_en && flip && !brk_e;
    chk(two_s ? "R5" : "R9", "char count", nrx - start, 1);
    chk("R2", "data", int'(log_d[start % 256]), int'(dm));
    chk("R4", "frame_err", int'(log_fe[start % 256]), int'(fe_e));
    chk("R3", "parity_err", int'(log_pe[start % 256]), int'(pe_e));
    chk("R6", "break", int'(log_brk[start % 256]), int'(brk_e));
  endtask

  initial begin
    int start;
    void'($urandom(32'h5eed_0042));
    repeat (5) @(negedge clk);
    chk("R1", "valid in reset", int'(valid_o), 0);
    chk("R1", "outputs in reset", int'({data_o, fe_o, pe_o, brk_o}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "outputs after reset", int'({valid_o, data_o, fe_o, pe_o, brk_o}), 0);

    // R2 word lengths
    for (int w = 0; w < 4; w++) run_frame(8'hFF, 2'(w), 0, 0, 0, 1, 1, 0);
    run_frame(8'h96, 2'd3, 0, 0, 0, 1, 1, 0);
    // R3 parity, good and flipped
    run_frame(8'h37, 2'd3, 1, 0, 0, 1, 1, 0);
    run_frame(8'h37, 2'd3, 1, 1, 0, 1, 1, 0);
    run_frame(8'h0B, 2'd2, 1, 0, 0, 1, 1, 1);
    run_frame(8'h0B, 2'd2, 1, 1, 0, 1, 1, 1);
    // R4 framing error
    run_frame(8'h55, 2'd3, 0, 0, 0, 0, 1, 0);
    // R5 low second stop bit
    run_frame(8'hC3, 2'd3, 0, 0, 1, 1, 0, 0);
    // R6 all-zero frame with even parity is a break
    run_frame(8'h00, 2'd3, 1, 0, 0, 0, 1, 0);
    // R10 continuous tick
    tdiv = 1;
    run_frame(8'hA5, 2'd3, 1, 1, 1, 1, 1, 0);
    tdiv = 4;

    // R6/R7 long break then recovery
    wlen = 2'd3; pen = 0; two = 0;
    start = nrx;
    rxd = 1'b0; wait_bits(30);
    chk("R7", "chars during held break", nrx - start, 1);
    chk("R6", "break data", int'(log_d[start % 256]), 0);
    chk("R6", "break flag", int'(log_brk[start % 256]), 1);
    chk("R6", "break no frame_err", int'(log_fe[start % 256]), 0);
    rxd = 1'b1; wait_bits(2);
    chk("R7", "no char on release", nrx - start, 1);
    run_frame(8'h3C, 2'd3, 0, 0, 0, 1, 1, 0);

    // R8 false start
    start = nrx;
    rxd = 1'b0; repeat (4 * tdiv) @(negedge clk);
    rxd = 1'b1; wait_bits(3);
    chk("R8", "false start chars", nrx - start, 0);

    // random frames
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d = 8'($urandom);
      if ($urandom_range(0, 9) == 0) d = 8'h00;
      tdiv = $urandom_range(1, 4);
      run_frame(d, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                $urandom_range(0, 7) != 0, 1'($urandom_range(0, 1)),
                $urandom_range(0, 7) == 0);
    end

    chk("R9", "adjacent strobes", adjacent, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule